// File: doc/BRIEF.md
# Processor status word and interrupt acceptance unit

This unit holds the 16-bit status word of a small processor core and decides, in the same cycle, whether a pending interrupt may be taken. A maskable request is taken only when both a global enable flag and a local enable flag in the status word are set. A non-maskable request is always taken, and it is reported as its own class. The core's sequencer pulses an entry strobe when it begins servicing an interrupt and a return strobe when the service routine finishes. The global enable flag clears on entry and sets again on return, with no software action needed.

Reset is synchronous. The first reset cycle loads the status word with only the local enable flag set. It also hands the word held just before reset to the register file, together with a one-cycle load pulse aimed at general register R1. Start-up code can then inspect the state the core was in before the reset. A software write port updates either the status word or a 16-bit configuration register. That register resets to zero, and bit 0 of it chooses between a 16-bit and a wider interrupt base register.

Top module: `psr_core`

## Requirements
- R1: `irq_accept_o` is high in the same cycle as `mask_req_i` only when status bit 11 (global enable) and status bit 9 (local enable) are both 1; then `irq_class_o` is 0 (maskable) unless a non-maskable request is also present.
- R2: A high `nmi_req_i` raises `irq_accept_o` in the same cycle whatever the status word holds, with `irq_class_o` = 1.
- R3: When both request classes are present and accepted in one cycle, `irq_class_o` is 1.
- R4: A high `int_enter_i` makes status bit 11 read 0 after the next clock edge and leaves every other status bit unchanged.
- R5: A high `int_return_i` makes status bit 11 read 1 after the next clock edge. If `int_enter_i` is also high, entry wins and the bit reads 0.
- R6: Any clock edge with `rst_i` high leaves the status word at 16'h0200 (only bit 9 set).
- R7: At the first edge of a reset pulse, `r1_data_o` takes the status word held just before that edge and `r1_load_o` is high for exactly one cycle. Later edges of the same reset pulse neither reload nor pulse.
- R8: Status bits 3, 4, 8 and 12 to 15 are reserved. They always read 0 and ignore writes; the writable mask is 16'h0EE7.
- R9: With `sw_wr_i` high and `sw_sel_i` = 0, the status word takes `sw_data_i` masked by 16'h0EE7 after the next edge. The write is dropped entirely when `int_enter_i` or `int_return_i` is high in the same cycle.
- R10: With `sw_wr_i` high and `sw_sel_i` = 1, the configuration register takes all 16 bits of `sw_data_i` after the next edge. It reads 0 after reset, and `ibase_wide_o` equals its bit 0 (0 selects a 16-bit interrupt base).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mask_req_i | input | 1 | Maskable interrupt request |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| int_enter_i | input | 1 | Interrupt entry strobe from the sequencer |
| int_return_i | input | 1 | Service-routine return strobe |
| sw_wr_i | input | 1 | Software write enable |
| sw_sel_i | input | 1 | Write target: 0 status word, 1 configuration |
| sw_data_i | input | 16 | Software write data |
| status_o | output | 16 | Current status word |
| cfg_o | output | 16 | Current configuration register |
| ibase_wide_o | output | 1 | 1 when a wider interrupt base is selected |
| irq_accept_o | output | 1 | An interrupt is accepted this cycle |
| irq_class_o | output | 1 | Class of the accepted interrupt: 1 non-maskable |
| r1_data_o | output | 16 | Status word captured at reset, for R1 |
| r1_load_o | output | 1 | One-cycle load strobe for R1 |

## Verification
Several rules are checked by assertions on every cycle: the enable gating of maskable acceptance, the unconditional acceptance of non-maskable requests, the per-strobe updates of the global enable, the reset value, the reserved bits staying zero, and hardware updates taking precedence over software writes. Other behaviour needs the bench's scenarios. Only a full sequence shows that the word captured into R1 is the one from before reset, and that no second capture happens during a long reset. The exact masked value left by a software write, and configuration writes reaching the base-width output, are shown by comparison with a reference model under random stimulus.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int PSR_W     = 16;
    localparam int GIE_BIT   = 11;
    localparam int LIE_BIT   = 9;
    localparam logic [PSR_W-1:0] PSR_WMASK = 16'h0EE7;
    localparam logic [PSR_W-1:0] PSR_RESET = PSR_W'(1) << LIE_BIT;
    localparam logic [PSR_W-1:0] CFG_RESET = '0;

    typedef enum logic {
        WSEL_STATUS = 1'b0,
        WSEL_CFG    = 1'b1
    } wsel_e;

    typedef struct packed {
        logic [PSR_W-1:0] status;
        logic [PSR_W-1:0] r1_data;
        logic             r1_load;
        logic             rst_seen;
    } psr_state_t;
endpackage

// File: rtl/psr_irq_gate.sv
module psr_irq_gate #(
    parameter int W       = psr_pkg::PSR_W,
    parameter int GIE_POS = psr_pkg::GIE_BIT,
    parameter int LIE_POS = psr_pkg::LIE_BIT
) (
    input  logic [W-1:0] status_i,
    input  logic         mask_req_i,
    input  logic         nmi_req_i,
    output logic         accept_o,
    output logic         class_o
);
    logic mask_ok;

    always_comb begin
        mask_ok  = mask_req_i & status_i[GIE_POS] & status_i[LIE_POS];
        accept_o = nmi_req_i | mask_ok;
        // non-maskable has priority when both are taken
        class_o  = nmi_req_i;
    end
endmodule

// File: rtl/psr_status_next.sv
module psr_status_next #(
    parameter int              W       = psr_pkg::PSR_W,
    parameter int              GIE_POS = psr_pkg::GIE_BIT,
    parameter logic [W-1:0]    WMASK   = psr_pkg::PSR_WMASK
) (
    input  logic [W-1:0] status_q_i,
    input  logic         enter_i,
    input  logic         return_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] status_d_o
);
    logic [W-1:0] masked_wr;
    logic [W-1:0] hw_upd;
    logic         hw_busy;

    // per-bit mask: reserved positions are tied low
    for (genvar b = 0; b < W; b++) begin : g_mask
        if (WMASK[b]) begin : g_live
            assign masked_wr[b] = wr_data_i[b];
        end else begin : g_rsvd
            assign masked_wr[b] = 1'b0;
        end
    end

    always_comb begin
        hw_busy = enter_i | return_i;
        hw_upd  = status_q_i;
        hw_upd[GIE_POS] = ~enter_i;
        if (hw_busy) begin
            status_d_o = hw_upd & WMASK;
        end else if (wr_i) begin
            status_d_o = masked_wr;
        end else begin
            status_d_o = status_q_i & WMASK;
        end
    end
endmodule

// File: rtl/psr_cfg_reg.sv
module psr_cfg_reg #(
    parameter int           W     = psr_pkg::PSR_W,
    parameter logic [W-1:0] RESET = psr_pkg::CFG_RESET
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic         wr_i,
    input  logic [W-1:0] wr_data_i,
    output logic [W-1:0] cfg_o,
    output logic         wide_o
);
    logic [W-1:0] cfg_d;
    logic [W-1:0] cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (rst_i) begin
            cfg_d = RESET;
        end else if (wr_i) begin
            cfg_d = wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o  = cfg_q;
    assign wide_o = cfg_q[0];
endmodule

// File: rtl/psr_core.sv
module psr_core
    import psr_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              mask_req_i,
    input  logic              nmi_req_i,
    input  logic              int_enter_i,
    input  logic              int_return_i,
    input  logic              sw_wr_i,
    input  logic              sw_sel_i,
    input  logic [PSR_W-1:0]  sw_data_i,
    output logic [PSR_W-1:0]  status_o,
    output logic [PSR_W-1:0]  cfg_o,
    output logic              ibase_wide_o,
    output logic              irq_accept_o,
    output logic              irq_class_o,
    output logic [PSR_W-1:0]  r1_data_o,
    output logic              r1_load_o
);
    psr_state_t       st_d;
    psr_state_t       st_q;
    logic [PSR_W-1:0] status_nx;
    logic             wr_status;
    logic             wr_cfg;

    assign wr_status = sw_wr_i & (wsel_e'(sw_sel_i) == WSEL_STATUS);
    assign wr_cfg    = sw_wr_i & (wsel_e'(sw_sel_i) == WSEL_CFG) & ~rst_i;

    psr_irq_gate #(.W(PSR_W), .GIE_POS(GIE_BIT), .LIE_POS(LIE_BIT)) u_gate (
        .status_i   (st_q.status),
        .mask_req_i (mask_req_i),
        .nmi_req_i  (nmi_req_i),
        .accept_o   (irq_accept_o),
        .class_o    (irq_class_o)
    );

    psr_status_next #(.W(PSR_W), .GIE_POS(GIE_BIT), .WMASK(PSR_WMASK)) u_next (
        .status_q_i (st_q.status),
        .enter_i    (int_enter_i),
        .return_i   (int_return_i),
        .wr_i       (wr_status),
        .wr_data_i  (sw_data_i),
        .status_d_o (status_nx)
    );

    psr_cfg_reg #(.W(PSR_W), .RESET(CFG_RESET)) u_cfg (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_i      (wr_cfg),
        .wr_data_i (sw_data_i),
        .cfg_o     (cfg_o),
        .wide_o    (ibase_wide_o)
    );

    always_comb begin
        st_d         = st_q;
        st_d.r1_load = 1'b0;
        if (rst_i) begin
            st_d.status   = PSR_RESET;
            st_d.rst_seen = 1'b1;
            if (!st_q.rst_seen) begin
                st_d.r1_data = st_q.status;
                st_d.r1_load = 1'b1;
            end
        end else begin
            st_d.status   = status_nx;
            st_d.rst_seen = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign status_o  = st_q.status;
    assign r1_data_o = st_q.r1_data;
    assign r1_load_o = st_q.r1_load;
endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk
    import psr_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             mask_req_i,
    input logic             nmi_req_i,
    input logic             int_enter_i,
    input logic             int_return_i,
    input logic             sw_wr_i,
    input logic [PSR_W-1:0] status_o,
    input logic [PSR_W-1:0] cfg_o,
    input logic             irq_accept_o,
    input logic             irq_class_o
);
    a_r1_mask_gated: assert property (@(posedge clk_i) disable iff (rst_i)
        (irq_accept_o && !nmi_req_i) |-> (status_o[GIE_BIT] && status_o[LIE_BIT] && mask_req_i));

    a_r2_nmi_taken: assert property (@(posedge clk_i) disable iff (rst_i)
        nmi_req_i |-> (irq_accept_o && irq_class_o));

    a_r3_nmi_wins: assert property (@(posedge clk_i) disable iff (rst_i)
        (nmi_req_i && mask_req_i) |-> irq_class_o);

    a_r4_enter_clears: assert property (@(posedge clk_i) disable iff (rst_i)
        int_enter_i |=> !status_o[GIE_BIT]);

    a_r5_return_sets: assert property (@(posedge clk_i) disable iff (rst_i)
        (int_return_i && !int_enter_i) |=> status_o[GIE_BIT]);

    a_r6_reset_value: assert property (@(posedge clk_i)
        rst_i |=> (status_o == PSR_RESET));

    a_r8_reserved_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (status_o & ~PSR_WMASK) == '0);

    a_r9_hw_over_sw: assert property (@(posedge clk_i) disable iff (rst_i)
        (sw_wr_i && (int_enter_i || int_return_i)) |=>
        ((status_o & ~(PSR_W'(1) << GIE_BIT)) == ($past(status_o) & ~(PSR_W'(1) << GIE_BIT))));

    a_r10_cfg_reset: assert property (@(posedge clk_i)
        rst_i |=> (cfg_o == CFG_RESET));
endmodule

bind psr_core psr_core_chk u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .mask_req_i   (mask_req_i),
    .nmi_req_i    (nmi_req_i),
    .int_enter_i  (int_enter_i),
    .int_return_i (int_return_i),
    .sw_wr_i      (sw_wr_i),
    .status_o     (status_o),
    .cfg_o        (cfg_o),
    .irq_accept_o (irq_accept_o),
    .irq_class_o  (irq_class_o)
);

// File: tb/sim_psr_core.sv
module sim_psr_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mreq = 1'b0, nreq = 1'b0, ent = 1'b0, ext = 1'b0;
    logic        wr = 1'b0, sel = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] status, cfg, r1_data;
    logic        wide, acc, cls, r1_load;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [15:0] m_status = 16'h0200;
    logic [15:0] m_cfg    = 16'h0000;
    logic [15:0] m_r1     = 16'h0000;
    logic        m_load   = 1'b0;
    logic        m_rprev  = 1'b1;
    bit          r1_known = 0;
    string       tag      = "R6";

    always #10 clk = ~clk;

    psr_core u0 (
        .clk_i(clk), .rst_i(rst), .mask_req_i(mreq), .nmi_req_i(nreq),
        .int_enter_i(ent), .int_return_i(ext), .sw_wr_i(wr), .sw_sel_i(sel),
        .sw_data_i(wdata), .status_o(status), .cfg_o(cfg), .ibase_wide_o(wide),
        .irq_accept_o(acc), .irq_class_o(cls), .r1_data_o(r1_data), .r1_load_o(r1_load)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_accept(input logic [15:0] s, input logic m, input logic n);
        return n | (m & s[11] & s[9]);
    endfunction

    task automatic model_step();
        if (rst) begin
            tag = "R6";
            if (!m_rprev) begin
                m_r1 = m_status; m_load = 1'b1;
            end else begin
                m_load = 1'b0;
            end
            m_status = 16'h0200; m_cfg = 16'h0000; m_rprev = 1'b1;
        end else begin
            m_rprev = 1'b0; m_load = 1'b0;
            if (ent) begin
                m_status[11] = 1'b0; tag = "R4";
            end else if (ext) begin
                m_status[11] = 1'b1; tag = "R5";
            end else if (wr && !sel) begin
                m_status = wdata & 16'h0EE7; tag = "R9";
            end else begin
                tag = "R8";
            end
            if (wr && sel) m_cfg = wdata;
        end
    endtask

    task automatic cyc(input logic r, input logic m, input logic n, input logic e,
                       input logic x, input logic w, input logic s, input logic [15:0] d);
        @(negedge clk);
        chk(tag, status, m_status);
        chk("R10", cfg, m_cfg);
        chk("R10", {15'b0, wide}, {15'b0, m_cfg[0]});
        chk("R8", status & 16'hF118, 16'h0000);
        if (r1_known) begin
            chk("R7", {15'b0, r1_load}, {15'b0, m_load});
            chk("R7", r1_data, m_r1);
        end
        rst = r; mreq = m; nreq = n; ent = e; ext = x; wr = w; sel = s; wdata = d;
        #2;
        if (!r) begin
            chk(n ? "R2" : "R1", {15'b0, acc}, {15'b0, exp_accept(m_status, m, n)});
            if (acc) chk((n && m) ? "R3" : "R2", {15'b0, cls}, {15'b0, n});
        end
        @(posedge clk);
        #1;
        model_step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R6 reset state, R10 cfg reset
        cyc(1,0,0,0,0,0,0,0);
        cyc(1,0,0,0,0,0,0,0);
        cyc(0,0,0,0,0,0,0,0);
        r1_known = 1;
        // R1: maskable rejected with global enable clear
        cyc(0,1,0,0,0,0,0,0);
        // R8/R9: write all ones
        cyc(0,0,0,0,0,1,0,16'hFFFF);
        // R1: now accepted, R3 both pending
        cyc(0,1,0,0,0,0,0,0);
        cyc(0,1,1,0,0,0,0,0);
        // R4 entry clears global enable; R2 nmi still taken
        cyc(0,0,0,1,0,0,0,0);
        cyc(0,1,1,0,0,0,0,0);
        // R5 return sets; R9 write dropped alongside entry
        cyc(0,0,0,0,1,0,0,0);
        cyc(0,0,0,1,1,1,0,16'h0000);
        cyc(0,0,0,0,1,1,0,16'h0000);
        // R10 cfg write selects wide base
        cyc(0,0,0,0,0,1,1,16'hA5A5);
        cyc(0,0,0,0,0,1,1,16'h0002);
        // R7 long reset from a non-default status
        cyc(0,0,0,0,0,1,0,16'h0CA3);
        cyc(1,0,0,0,0,0,0,0);
        cyc(1,0,0,0,0,0,0,0);
        cyc(1,0,0,0,0,0,0,0);
        cyc(0,0,0,0,0,0,0,0);
        cyc(0,0,0,0,0,0,0,0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 60) == 0, $urandom % 2, ($urandom % 6) == 0,
                ($urandom % 8) == 0, ($urandom % 8) == 0, ($urandom % 4) == 0,
                $urandom % 2, 16'($urandom));
        end
        cyc(0,0,0,0,0,0,0,0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule